// File: doc/BRIEF.md
# Stable Odd-Even Transposition Index Sorter

This block takes one list of `N_KEYS` unsigned 16-bit keys, loaded in parallel on a start pulse, and sorts it into ascending order. It returns the permutation, not the keys: for each sorted position, the block reports the zero-based position the key held in the input list. Downstream logic can then reorder whole records with that permutation. Equal keys keep the order they had in the input list.

The sort works on a row of registers. Every clock it applies one compare-exchange phase to the whole row, with all pairs handled in parallel. The phases alternate between pairs that start at even slots and pairs that start at odd slots. Each key carries its original position with it through every exchange. When the list length is odd, one extra slot is added at the end and holds the reserved key 65535. Legal keys run from 0 to 65534, so this padding key always sorts last and is never reported. A run takes a fixed number of clocks that depends only on the list length. A one-cycle done pulse marks the end of the run.

Top module: `oets_index_sorter`

## Requirements
- R1: While reset is held and after reset, `busy` and `done` are 0, and `idx_out` holds the identity order: slot i reads i.
- R2: After a run, slot p of `idx_out` (bits `[p*IDX_W +: IDX_W]`) holds the input position of the key with sorted rank p in ascending order. Input key i is read from `keys_in[i*16 +: 16]`.
- R3: Keys of equal value keep their input order in the result. A pair is exchanged only when the left key is strictly greater than the right key.
- R4: A start seen while idle is accepted at that clock edge. `busy` is then high for P clock cycles, one phase per cycle, where P is `N_KEYS` rounded up to even. `done` is high for exactly one cycle, the cycle after the last phase. Counting the accepting edge as edge 1, `done` is first visible after edge P+1.
- R5: `start` is ignored while `busy` is high. The result and the timing of the run in progress are unchanged. While idle and without `start`, `idx_out` holds its value even when `keys_in` changes.
- R6: For an odd `N_KEYS`, the padding slot (input position `N_KEYS`) never appears in `idx_out`. Every reported index is below `N_KEYS`.
- R7: Keys at the top legal value 65534 sort correctly next to the padding key, for both even and odd list lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run with the keys on `keys_in` (accepted only while idle) |
| keys_in | input | N_KEYS*16 | Input keys, key i in bits `[i*16 +: 16]`, values 0..65534 |
| busy | output | 1 | High while phases are being applied |
| done | output | 1 | One-cycle pulse after the final phase |
| idx_out | output | N_KEYS*IDX_W | Original positions in sorted order, slot p in bits `[p*IDX_W +: IDX_W]` |

## Verification
The sorter is tried with several kinds of input: an already ascending list, a fully descending list, a mixed list, a list where every key is equal, and an alternating pattern of 0 and 65534. It is also run with pseudo-random lists drawn from a narrow key range, so that duplicates occur often. The ascending and descending lists show whether enough phases run to move an element the full length of the row. The all-equal and duplicate-heavy lists expose any exchange of equal keys, which would break stability. The 65534 patterns and a second, odd-length instance show whether the padding slot stays last and out of the output. A start pulse in the middle of a run, and keys that change while the block is idle, check that the result is not disturbed.

// File: rtl/oets_pkg.sv
package oets_pkg;
    localparam int KEY_W = 16;
    localparam logic [KEY_W-1:0] PAD_KEY = '1;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_kind_e;
endpackage

// File: rtl/oets_cmpx.sv
module oets_cmpx
    import oets_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic [KEY_W-1:0] a_key,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [KEY_W-1:0] b_key,
    input  logic [IDX_W-1:0] b_idx,
    output logic [KEY_W-1:0] lo_key,
    output logic [IDX_W-1:0] lo_idx,
    output logic [KEY_W-1:0] hi_key,
    output logic [IDX_W-1:0] hi_idx
);
    logic swap;

    // strict compare: equal keys never move, which keeps the sort stable
    assign swap   = a_key > b_key;
    assign lo_key = swap ? b_key : a_key;
    assign lo_idx = swap ? b_idx : a_idx;
    assign hi_key = swap ? a_key : b_key;
    assign hi_idx = swap ? a_idx : b_idx;
endmodule

// File: rtl/oets_phase_net.sv
module oets_phase_net
    import oets_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int IDX_W = 3
) (
    input  phase_kind_e              kind,
    input  logic [SLOTS*KEY_W-1:0]   keys_i,
    input  logic [SLOTS*IDX_W-1:0]   idx_i,
    output logic [SLOTS*KEY_W-1:0]   keys_o,
    output logic [SLOTS*IDX_W-1:0]   idx_o
);
    localparam int EVEN_PAIRS = SLOTS / 2;
    localparam int ODD_PAIRS  = EVEN_PAIRS - 1;

    logic [SLOTS*KEY_W-1:0] ev_keys, od_keys;
    logic [SLOTS*IDX_W-1:0] ev_idx,  od_idx;

    for (genvar j = 0; j < EVEN_PAIRS; j++) begin : g_even
        oets_cmpx #(.IDX_W(IDX_W)) u_cell (
            .a_key (keys_i[(2*j)*KEY_W +: KEY_W]),
            .a_idx (idx_i [(2*j)*IDX_W +: IDX_W]),
            .b_key (keys_i[(2*j+1)*KEY_W +: KEY_W]),
            .b_idx (idx_i [(2*j+1)*IDX_W +: IDX_W]),
            .lo_key(ev_keys[(2*j)*KEY_W +: KEY_W]),
            .lo_idx(ev_idx [(2*j)*IDX_W +: IDX_W]),
            .hi_key(ev_keys[(2*j+1)*KEY_W +: KEY_W]),
            .hi_idx(ev_idx [(2*j+1)*IDX_W +: IDX_W])
        );
    end

    for (genvar j = 0; j < ODD_PAIRS; j++) begin : g_odd
        oets_cmpx #(.IDX_W(IDX_W)) u_cell (
            .a_key (keys_i[(2*j+1)*KEY_W +: KEY_W]),
            .a_idx (idx_i [(2*j+1)*IDX_W +: IDX_W]),
            .b_key (keys_i[(2*j+2)*KEY_W +: KEY_W]),
            .b_idx (idx_i [(2*j+2)*IDX_W +: IDX_W]),
            .lo_key(od_keys[(2*j+1)*KEY_W +: KEY_W]),
            .lo_idx(od_idx [(2*j+1)*IDX_W +: IDX_W]),
            .hi_key(od_keys[(2*j+2)*KEY_W +: KEY_W]),
            .hi_idx(od_idx [(2*j+2)*IDX_W +: IDX_W])
        );
    end

    // end slots sit out the odd phase
    assign od_keys[0 +: KEY_W]             = keys_i[0 +: KEY_W];
    assign od_idx [0 +: IDX_W]             = idx_i [0 +: IDX_W];
    assign od_keys[(SLOTS-1)*KEY_W +: KEY_W] = keys_i[(SLOTS-1)*KEY_W +: KEY_W];
    assign od_idx [(SLOTS-1)*IDX_W +: IDX_W] = idx_i [(SLOTS-1)*IDX_W +: IDX_W];

    assign keys_o = (kind == PH_ODD) ? od_keys : ev_keys;
    assign idx_o  = (kind == PH_ODD) ? od_idx  : ev_idx;
endmodule

// File: rtl/oets_index_sorter.sv
module oets_index_sorter
    import oets_pkg::*;
#(
    parameter int N_KEYS = 8,
    localparam int SLOTS = N_KEYS + (N_KEYS % 2),
    localparam int IDX_W = (SLOTS > 2) ? $clog2(SLOTS) : 1,
    localparam int PH_W  = (SLOTS > 2) ? $clog2(SLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [N_KEYS*KEY_W-1:0] keys_in,
    output logic                    busy,
    output logic                    done,
    output logic [N_KEYS*IDX_W-1:0] idx_out
);
    localparam logic [PH_W-1:0] LAST_PHASE = PH_W'(SLOTS - 1);

    typedef struct packed {
        logic                   busy;
        logic                   done;
        logic [PH_W-1:0]        phase;
        logic [SLOTS*KEY_W-1:0] keys;
        logic [SLOTS*IDX_W-1:0] idx;
    } state_t;

    function automatic logic [SLOTS*IDX_W-1:0] identity_order();
        logic [SLOTS*IDX_W-1:0] r;
        for (int i = 0; i < SLOTS; i++) r[i*IDX_W +: IDX_W] = IDX_W'(i);
        return r;
    endfunction

    function automatic logic [SLOTS*KEY_W-1:0] pad_keys(input logic [N_KEYS*KEY_W-1:0] k);
        logic [SLOTS*KEY_W-1:0] r;
        for (int i = 0; i < SLOTS; i++)
            r[i*KEY_W +: KEY_W] = (i < N_KEYS) ? k[i*KEY_W +: KEY_W] : PAD_KEY;
        return r;
    endfunction

    localparam state_t RESET_STATE = '{
        busy:  1'b0,
        done:  1'b0,
        phase: '0,
        keys:  '0,
        idx:   identity_order()
    };

    state_t state_d, state_q;

    phase_kind_e            net_kind;
    logic [SLOTS*KEY_W-1:0] net_keys;
    logic [SLOTS*IDX_W-1:0] net_idx;

    assign net_kind = phase_kind_e'(state_q.phase[0]);

    oets_phase_net #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_net (
        .kind  (net_kind),
        .keys_i(state_q.keys),
        .idx_i (state_q.idx),
        .keys_o(net_keys),
        .idx_o (net_idx)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (!state_q.busy) begin
            if (start) begin
                state_d.busy  = 1'b1;
                state_d.phase = '0;
                state_d.keys  = pad_keys(keys_in);
                state_d.idx   = identity_order();
            end
        end else begin
            state_d.keys  = net_keys;
            state_d.idx   = net_idx;
            state_d.phase = state_q.phase + 1'b1;
            if (state_q.phase == LAST_PHASE) begin
                state_d.busy  = 1'b0;
                state_d.done  = 1'b1;
                state_d.phase = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RESET_STATE;
        else        state_q <= state_d;
    end

    assign busy    = state_q.busy;
    assign done    = state_q.done;
    assign idx_out = state_q.idx[N_KEYS*IDX_W-1:0];
endmodule

// File: rtl/oets_checker.sv
module oets_checker #(
    parameter int N_KEYS = 8,
    parameter int IDX_W  = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic [N_KEYS*IDX_W-1:0] idx_out
);
    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    assert_start_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_busy_continues_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |=> (busy || done));

    assert_not_busy_and_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(idx_out));

    for (genvar p = 0; p < N_KEYS; p++) begin : g_range
        assert_index_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> (int'(idx_out[p*IDX_W +: IDX_W]) < N_KEYS));
    end
endmodule

bind oets_index_sorter oets_checker #(.N_KEYS(N_KEYS), .IDX_W(IDX_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .idx_out(idx_out)
);

// File: tb/sim_oets_index_sorter.sv
module sim_oets_index_sorter;
    localparam int CLK_PERIOD = 10;
    localparam int N0 = 8;
    localparam int N1 = 5;
    localparam int KW = 16;
    localparam int IW = 3;
    localparam int NV = 6;
    localparam int LAT0 = 9;   // P=8: done seen after edge P+1
    localparam int LAT1 = 7;   // P=6

    localparam int VK [NV][N0] = '{
        '{7, 1, 6, 3, 4, 5, 2, 8},
        '{5, 5, 5, 5, 5, 5, 5, 5},
        '{8, 7, 6, 5, 4, 3, 2, 1},
        '{1, 3, 8, 5, 6, 7, 2, 5},
        '{65534, 0, 65534, 0, 65534, 0, 65534, 0},
        '{10, 20, 30, 40, 50, 60, 70, 80}
    };
    localparam int VE [NV][N0] = '{
        '{1, 6, 3, 4, 5, 2, 0, 7},
        '{0, 1, 2, 3, 4, 5, 6, 7},
        '{7, 6, 5, 4, 3, 2, 1, 0},
        '{0, 6, 1, 3, 7, 4, 5, 2},
        '{1, 3, 5, 7, 0, 2, 4, 6},
        '{0, 1, 2, 3, 4, 5, 6, 7}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start0 = 1'b0, start1 = 1'b0;
    logic [N0*KW-1:0] keys0 = '0;
    logic [N1*KW-1:0] keys1 = '0;
    logic busy0, done0, busy1, done1;
    logic [N0*IW-1:0] idx0;
    logic [N1*IW-1:0] idx1;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oets_index_sorter #(.N_KEYS(N0)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start0), .keys_in(keys0),
        .busy(busy0), .done(done0), .idx_out(idx0)
    );

    oets_index_sorter #(.N_KEYS(N1)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start1), .keys_in(keys1),
        .busy(busy1), .done(done1), .idx_out(idx1)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // run u0 with keys0 already set; returns cycles until done seen
    task automatic run0(output int lat);
        @(negedge clk);
        start0 = 1'b1;
        lat = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            start0 = 1'b0;
            lat++;
        end while (!done0 && lat < 100);
    endtask

    task automatic run1(output int lat);
        @(negedge clk);
        start1 = 1'b1;
        lat = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            start1 = 1'b0;
            lat++;
        end while (!done1 && lat < 100);
    endtask

    // stable rank of key i = smaller keys + equal keys earlier in the list
    task automatic check_ref0(input string req, input int k [N0]);
        int exp [N0];
        for (int i = 0; i < N0; i++) begin
            int pos = 0;
            for (int j = 0; j < N0; j++)
                if (k[j] < k[i] || (k[j] == k[i] && j < i)) pos++;
            exp[pos] = i;
        end
        for (int p = 0; p < N0; p++)
            check(req, int'(idx0[p*IW +: IW]), exp[p]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int lat;
        int rk [N0];
        int kk [N0];
        logic [N0*IW-1:0] held;
        logic [31:0] seed;

        // R1: state under reset
        repeat (3) @(negedge clk);
        check("R1 busy in reset", int'(busy0), 0);
        check("R1 done in reset", int'(done0), 0);
        for (int p = 0; p < N0; p++) check("R1 identity idx", int'(idx0[p*IW +: IW]), p);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", int'(busy0), 0);
        check("R1 done after reset", int'(done1), 0);

        // table of vectors: R2 main function, R3 stability, R7 top key
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < N0; i++) keys0[i*KW +: KW] = KW'(VK[v][i]);
            run0(lat);
            check("R4 latency", lat, LAT0);
            for (int p = 0; p < N0; p++)
                check((v == 1) ? "R3 equal keys" : (v == 4) ? "R7 top key" : "R2 sorted idx",
                      int'(idx0[p*IW +: IW]), VE[v][p]);
            @(negedge clk);
            check("R4 done single cycle", int'(done0), 0);
            check("R4 busy low after run", int'(busy0), 0);
        end

        // R5: idle and keys change without start -> hold
        held = idx0;
        for (int i = 0; i < N0; i++) keys0[i*KW +: KW] = KW'(i * 3);
        repeat (4) @(negedge clk);
        check("R5 idle hold", int'(idx0), int'(held));

        // R5: start during a run is ignored
        for (int i = 0; i < N0; i++) keys0[i*KW +: KW] = KW'(VK[0][i]);
        @(negedge clk);
        start0 = 1'b1;
        lat = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            lat++;
            start0 = 1'b0;
            if (lat == 2) begin
                for (int i = 0; i < N0; i++) keys0[i*KW +: KW] = KW'(VK[2][i]);
                start0 = 1'b1;
            end
        end while (!done0 && lat < 100);
        check("R5 latency with mid start", lat, LAT0);
        for (int p = 0; p < N0; p++) check("R5 mid start result", int'(idx0[p*IW +: IW]), VE[0][p]);

        // R6/R7: odd-length instance with padding slot
        keys1 = {16'd0, 16'd3, 16'd65534, 16'd3, 16'd65534};
        run1(lat);
        check("R4 odd latency", lat, LAT1);
        check("R6 pad slot0", int'(idx1[0*IW +: IW]), 4);
        check("R6 pad slot1", int'(idx1[1*IW +: IW]), 1);
        check("R6 pad slot2", int'(idx1[2*IW +: IW]), 3);
        check("R7 odd top0", int'(idx1[3*IW +: IW]), 0);
        check("R7 odd top1", int'(idx1[4*IW +: IW]), 2);
        keys1 = {16'd1, 16'd2, 16'd3, 16'd4, 16'd5};
        run1(lat);
        for (int p = 0; p < N1; p++) check("R6 odd descending", int'(idx1[p*IW +: IW]), N1 - 1 - p);

        // R2/R3: pseudo-random lists, narrow range for duplicates
        seed = 32'h1234_5678;
        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < N0; i++) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                rk[i] = (t % 2 == 0) ? int'(seed[18:16] % 3) : int'(seed[31:16] % 65535);
                keys0[i*KW +: KW] = KW'(rk[i]);
            end
            kk = rk;
            run0(lat);
            check("R4 random latency", lat, LAT0);
            check_ref0((t % 2 == 0) ? "R3 random dups" : "R2 random", kk);
        end

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule